// File: doc/BRIEF.md
# IEC958 AM824 Label Generator

This block turns a stream of 16-bit PCM samples into 32-bit AM824 quadlets. Each quadlet carries an 8-bit label in its top byte and the sample in the middle two bytes. The low byte is zero. A sample is presented with a valid flag, a subframe (channel) index, a format select and a sample-rate select. The quadlet appears one clock later with its own valid flag.

In the two IEC958 formats (linear PCM and compressed audio), the label carries four flags for each subframe:

- a consumer channel-status bit,
- an even-parity bit,
- a first-subframe flag,
- a block-start flag.

A frame counter tracks the position inside a 192-frame channel-status block. It steps once per stereo event. In raw format the label is a fixed constant, and any channel index is accepted.

The block sits between a sample source and a packetizer. The packetizer counts the valid quadlets and wraps them into packets.

Top module: `am824_labeler`

## Requirements
- R1: In IEC958 formats the frame counter starts at 0 after reset and counts 0..191. It advances by one after an accepted sample with subframe index 1, and wraps from 191 to 0. It does not advance on subframe 0, in raw format or on idle cycles.
- R2: In any cycle where `fmtSel` differs from its value in the previous cycle, the frame counter is cleared. This applies to idle cycles too. A sample presented in that cycle is labelled as frame 0. The previous value after reset is raw.
- R3: At frame 1 the channel-status bit is 1 when `fmtSel` is 2 (compressed). It is 0 when `fmtSel` is 1 (PCM).
- R4: The channel-status bit is 1 at frames 2 and 9. It is 0 at every frame other than 1, 2, 9 and 24..27.
- R5: At frames 24, 25, 26 and 27 the channel-status bit is bit 3, 2, 1 and 0 of a 4-bit rate code, in that order. The code is 0xC for `rateSel`=0 (32 kHz), 0x4 for `rateSel`=2 (48 kHz), and 0x0 for every other `rateSel` value.
- R6: In IEC958 formats the label byte (quadlet bits 31:24) is laid out as follows:
  - bit 5: block start, 1 only at frame 0 with subframe 0;
  - bit 4: 1 when the subframe index is 0;
  - bit 3: parity;
  - bit 2: channel-status bit;
  - bits 7, 6, 1 and 0: zero.
- R7: The parity bit is the XOR of all 16 sample bits and the channel-status bit.
- R8: The sample occupies quadlet bits 23:8, and bits 7:0 are zero.
- R9: When `fmtSel` is 0 or 3 (raw), the label is 0x40, and samples with any subframe index 0..7 are accepted.
- R10: In IEC958 formats a valid sample with subframe index 2 or higher is dropped. No quadlet is produced, and the frame counter is left unchanged.
- R11: An accepted sample yields `quadValid`=1 exactly one cycle later. A cycle without an accepted sample yields `quadValid`=0 one cycle later. Reset clears `quadValid` and `quadOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 16 | PCM sample value |
| sampleValid | input | 1 | Sample present this cycle |
| subIdx | input | 3 | Subframe / channel index of the sample |
| fmtSel | input | 2 | 0 raw, 1 IEC958 PCM, 2 IEC958 compressed, 3 raw |
| rateSel | input | 3 | 0 32k, 1 44.1k, 2 48k, 3 88.2k, 4 96k, 5 176.4k, 6 192k |
| quadOut | output | 32 | Labelled AM824 quadlet |
| quadValid | output | 1 | Quadlet valid |

## Verification
A format switch and a frame-counter step can land in the same cycle. The clear must win, and the sample in that cycle must be labelled as frame 0. The bench provokes this by switching from PCM to compressed halfway through a block while a subframe-1 sample is being presented. It then checks two things: the block-start flag on the next subframe 0, and the compressed-audio status bit one frame later. A dropped out-of-range subframe can also arrive at the point where the counter would otherwise step. Such samples are placed between subframes 0 and 1, and the counter position is judged through the status bits of the samples that follow.

// File: rtl/am824_pkg.sv
package am824_pkg;

  localparam int SAMPLE_W = 16;
  localparam int LABEL_W  = 8;
  localparam int PAD_W    = 8;
  localparam int SUB_W    = 3;
  localparam int FRAMES   = 192;

  localparam int LBL_BLOCK = 5;
  localparam int LBL_FIRST = 4;
  localparam int LBL_PAR   = 3;
  localparam int LBL_CS    = 2;
  localparam logic [LABEL_W-1:0] RAW_LABEL = 8'h40;

  typedef enum logic [1:0] {
    FMT_RAW  = 2'd0,
    FMT_PCM  = 2'd1,
    FMT_COMP = 2'd2,
    FMT_RSV  = 2'd3
  } fmtKind_t;

  typedef struct packed {
    logic emit;
    logic iecMode;
    logic blockStart;
    logic firstSub;
    logic csBit;
  } labelCtl_t;

  function automatic logic [3:0] rateCode(input logic [2:0] rate);
    case (rate)
      3'd0:    rateCode = 4'hC;
      3'd2:    rateCode = 4'h4;
      default: rateCode = 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/am824_ctrl.sv
module am824_ctrl
  import am824_pkg::*;
#(
  parameter int FRAME_COUNT = FRAMES,
  parameter int SUBW        = SUB_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sampleValid,
  input  logic [SUBW-1:0] subIdx,
  input  logic [1:0]      fmtSel,
  input  logic [2:0]      rateSel,
  output labelCtl_t       ctl
);
  localparam int FRAME_W = $clog2(FRAME_COUNT);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAME_COUNT - 1);
  localparam logic [FRAME_W-1:0] F_COMP  = FRAME_W'(1);
  localparam logic [FRAME_W-1:0] F_CS_A  = FRAME_W'(2);
  localparam logic [FRAME_W-1:0] F_CS_B  = FRAME_W'(9);
  localparam logic [FRAME_W-1:0] F_RATE0 = FRAME_W'(24);
  localparam logic [FRAME_W-1:0] F_RATE3 = FRAME_W'(27);

  fmtKind_t            fmtPrev;
  fmtKind_t            fmtNow;
  logic [FRAME_W-1:0]  frameCnt;
  logic [FRAME_W-1:0]  effFrame;
  logic [FRAME_W-1:0]  nextFrame;
  logic                isIec;
  logic                fmtChange;
  logic                legalSub;
  logic                emit;
  logic                advance;
  logic                csBit;
  logic [3:0]          code;
  logic [1:0]          codeIdx;

  assign fmtNow    = fmtKind_t'(fmtSel);
  assign isIec     = (fmtNow == FMT_PCM) || (fmtNow == FMT_COMP);
  assign fmtChange = (fmtNow != fmtPrev);
  assign effFrame  = fmtChange ? '0 : frameCnt;
  assign legalSub  = !isIec || (subIdx < SUBW'(2));
  assign emit      = sampleValid && legalSub;
  assign advance   = emit && isIec && (subIdx == SUBW'(1));
  assign nextFrame = !advance ? effFrame :
                     (effFrame == LAST_FRAME) ? '0 : effFrame + FRAME_W'(1);

  assign code    = rateCode(rateSel);
  assign codeIdx = 2'(F_RATE3 - effFrame);

  always_comb begin
    csBit = 1'b0;
    if (effFrame == F_COMP)
      csBit = (fmtNow == FMT_COMP);
    else if (effFrame == F_CS_A || effFrame == F_CS_B)
      csBit = 1'b1;
    else if (effFrame >= F_RATE0 && effFrame <= F_RATE3)
      csBit = code[codeIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      fmtPrev  <= FMT_RAW;
    end else begin
      frameCnt <= nextFrame;
      fmtPrev  <= fmtNow;
    end
  end

  always_comb begin
    ctl.emit       = emit;
    ctl.iecMode    = isIec;
    ctl.blockStart = isIec && (effFrame == '0) && (subIdx == '0);
    ctl.firstSub   = (subIdx == '0);
    ctl.csBit      = isIec && csBit;
  end

  // R1: counter never leaves the block range
  assert_frame_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= LAST_FRAME);

  // R1: wrap after the last frame
  assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (advance && effFrame == LAST_FRAME) |=> (frameCnt == '0));

  // R2: a format switch leaves at most one step on the counter
  assert_fmt_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    fmtChange |=> (frameCnt <= FRAME_W'(1)));

  // R10: a dropped subframe leaves the counter alone
  assert_drop_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && isIec && !legalSub && !fmtChange) |=> $stable(frameCnt));

endmodule

// File: rtl/am824_datapath.sv
module am824_datapath
  import am824_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int LW = LABEL_W,
  parameter int PW = PAD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  labelCtl_t            ctl,
  input  logic [SW-1:0]        sampleIn,
  output logic [LW+SW+PW-1:0]  quadOut,
  output logic                 quadValid
);
  localparam int QW = LW + SW + PW;

  logic [SW:0]   parChain;
  logic [LW-1:0] iecLabel;
  logic [LW-1:0] label;

  assign parChain[0] = ctl.csBit;
  for (genvar gi = 0; gi < SW; gi++) begin : g_par
    assign parChain[gi+1] = parChain[gi] ^ sampleIn[gi];
  end

  always_comb begin
    iecLabel            = '0;
    iecLabel[LBL_BLOCK] = ctl.blockStart;
    iecLabel[LBL_FIRST] = ctl.firstSub;
    iecLabel[LBL_PAR]   = parChain[SW];
    iecLabel[LBL_CS]    = ctl.csBit;
    label = ctl.iecMode ? iecLabel : RAW_LABEL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quadOut   <= '0;
      quadValid <= 1'b0;
    end else begin
      quadValid <= ctl.emit;
      if (ctl.emit)
        quadOut <= {label, sampleIn, {PW{1'b0}}};
    end
  end

  // R7: IEC958 quadlets carry even parity over sample and status bit
  assert_parity_R7: assert property (@(posedge clk) disable iff (!rstN)
    (quadValid && !quadOut[QW-2]) |->
      (((^quadOut[QW-LW-1 -: SW]) ^ quadOut[QW-LW+LBL_CS]) == quadOut[QW-LW+LBL_PAR]));

  // R6: block start only on a first subframe
  assert_block_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (quadValid && quadOut[QW-LW+LBL_BLOCK]) |-> quadOut[QW-LW+LBL_FIRST]);

  // R8: low pad byte always zero
  assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    quadValid |-> (quadOut[PW-1:0] == '0));

endmodule

// File: rtl/am824_labeler.sv
module am824_labeler
  import am824_pkg::*;
#(
  parameter int SW   = SAMPLE_W,
  parameter int SUBW = SUB_W,
  parameter int NFRM = FRAMES
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SW-1:0]                sampleIn,
  input  logic                         sampleValid,
  input  logic [SUBW-1:0]              subIdx,
  input  logic [1:0]                   fmtSel,
  input  logic [2:0]                   rateSel,
  output logic [LABEL_W+SW+PAD_W-1:0]  quadOut,
  output logic                         quadValid
);
  labelCtl_t ctl;

  am824_ctrl #(.FRAME_COUNT(NFRM), .SUBW(SUBW)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .subIdx(subIdx),
    .fmtSel(fmtSel), .rateSel(rateSel), .ctl(ctl)
  );

  am824_datapath #(.SW(SW), .LW(LABEL_W), .PW(PAD_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .quadOut(quadOut), .quadValid(quadValid)
  );

  // R10: out-of-range subframe in IEC958 formats yields no quadlet
  assert_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && (fmtSel == 2'd1 || fmtSel == 2'd2) && subIdx > SUBW'(1))
      |=> !quadValid);

  // R11: no sample, no quadlet
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !quadValid);

  // R9: raw format always accepted
  assert_raw_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && (fmtSel == 2'd0 || fmtSel == 2'd3)) |=> quadValid);

endmodule

// File: tb/am824_labeler_tb_top.sv
module am824_labeler_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic [2:0]  subIdx = '0;
  logic [1:0]  fmtSel = '0;
  logic [2:0]  rateSel = '0;
  logic [31:0] quadOut;
  logic        quadValid;

  int nChecks = 0;
  int nErr = 0;
  int mFrame = 0;
  int mFmtPrev = 0;
  int kSeq = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  am824_labeler dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .subIdx(subIdx), .fmtSel(fmtSel), .rateSel(rateSel),
    .quadOut(quadOut), .quadValid(quadValid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int csExpect(input int f, input int fmt, input int rate);
    int code;
    code = (rate == 0) ? 12 : (rate == 2) ? 4 : 0;
    if (f == 1) return (fmt == 2) ? 1 : 0;
    if (f == 2 || f == 9) return 1;
    if (f >= 24 && f <= 27) return (code >> (27 - f)) & 1;
    return 0;
  endfunction

  function automatic string csTag(input int f, input bit change);
    if (change) return "R2";
    if (f == 0) return "R1";
    if (f == 1) return "R3";
    if (f == 2 || f == 9) return "R4";
    if (f >= 24 && f <= 27) return "R5";
    return "R4";
  endfunction

  function automatic logic [15:0] nextSample();
    kSeq++;
    if (kSeq % 17 == 0) return 16'hFFFF;
    if (kSeq % 23 == 0) return 16'h0000;
    return 16'(kSeq * 40503 + 12345);
  endfunction

  task automatic doSample(input logic [15:0] s, input int sub, input int fmt, input int rate);
    bit change, iec, legal;
    int eff, cs, par, ones;
    logic [7:0] expLbl;
    change = (fmt != mFmtPrev);
    eff    = change ? 0 : mFrame;
    iec    = (fmt == 1 || fmt == 2);
    legal  = !iec || sub < 2;
    cs     = iec ? csExpect(eff, fmt, rate) : 0;
    ones   = 0;
    for (int b = 0; b < 16; b++) ones += s[b];
    par    = (ones + cs) % 2;
    if (iec)
      expLbl = 8'((((eff == 0 && sub == 0) ? 1 : 0) << 5) | ((sub == 0 ? 1 : 0) << 4) | (par << 3) | (cs << 2));
    else
      expLbl = 8'h40;
    sampleIn = s; subIdx = 3'(sub); fmtSel = 2'(fmt); rateSel = 3'(rate); sampleValid = 1'b1;
    @(posedge clk); #1;
    sampleValid = 1'b0;
    if (legal) begin
      chk(quadValid === 1'b1, "R11", {31'b0, quadValid}, 32'd1);
      chk(quadOut[23:0] === {s, 8'h00}, "R8", {8'b0, quadOut[23:0]}, {8'b0, s, 8'h00});
      if (!iec) begin
        chk(quadOut[31:24] === expLbl, "R9", {24'b0, quadOut[31:24]}, {24'b0, expLbl});
      end else begin
        chk(quadOut[26] === cs[0], csTag(eff, change), {31'b0, quadOut[26]}, 32'(cs));
        chk(quadOut[27] === par[0], "R7", {31'b0, quadOut[27]}, 32'(par));
        chk(quadOut[31:24] === expLbl, "R6", {24'b0, quadOut[31:24]}, {24'b0, expLbl});
      end
    end else begin
      chk(quadValid === 1'b0, "R10", {31'b0, quadValid}, 32'd0);
    end
    if (legal && iec && sub == 1) mFrame = (eff == 191) ? 0 : eff + 1;
    else mFrame = eff;
    mFmtPrev = fmt;
  endtask

  task automatic idle(input int fmt);
    sampleValid = 1'b0; fmtSel = 2'(fmt);
    @(posedge clk); #1;
    chk(quadValid === 1'b0, "R11", {31'b0, quadValid}, 32'd0);
    if (fmt != mFmtPrev) mFrame = 0;
    mFmtPrev = fmt;
  endtask

  task automatic runFrames(input int n, input int fmt, input int rate);
    for (int f = 0; f < n; f++) begin
      doSample(nextSample(), 0, fmt, rate);
      doSample(nextSample(), 1, fmt, rate);
      if (f % 7 == 3) idle(fmt);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nErr, nChecks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(quadValid === 1'b0 && quadOut === 32'h0, "R11", quadOut, 32'h0);
    rstN = 1'b1;
    // PCM at 48k: two full blocks plus wrap (R1, R4, R5)
    runFrames(2 * 192 + 5, 1, 2);
    // compressed at 32k, switch from PCM (R2, R3, R5)
    runFrames(200, 2, 0);
    // PCM at 44.1k: rate bits all zero (R5)
    runFrames(40, 1, 1);
    // mid-block switch while a step is due (R2)
    runFrames(50, 1, 0);
    doSample(nextSample(), 0, 1, 0);
    doSample(nextSample(), 1, 2, 0);
    runFrames(30, 2, 0);
    // idle-cycle format switch clears the counter (R2)
    runFrames(12, 1, 2);
    idle(2);
    idle(1);
    runFrames(12, 1, 2);
    // out-of-range subframes dropped between subframes 0 and 1 (R10)
    for (int f = 0; f < 12; f++) begin
      doSample(nextSample(), 0, 1, 2);
      for (int s = 2; s < 8; s++) doSample(nextSample(), s, 1, 2);
      doSample(nextSample(), 1, 1, 2);
    end
    // raw formats, any channel (R9)
    for (int e = 0; e < 20; e++)
      for (int s = 0; s < 8; s++) doSample(nextSample(), s, (e < 10) ? 0 : 3, 4);
    // back to PCM starts a fresh block (R2)
    runFrames(30, 1, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule